// File: doc/BRIEF.md
# Masked Variable Funnel Shifter for Packed Vectors

This block is a vector datapath stage that runs a left funnel shift in every lane of a packed vector up to 512 bits wide. In each lane the current destination element and the matching element of a second source are joined into one value of twice the element width. The destination element forms the upper half. That value is shifted left by a per-lane count, and the upper half of the shifted value becomes the new lane result. Element size (16, 32 or 64 bits) and active vector length (128, 256 or 512 bits) are chosen with each operation.

A per-lane write mask decides which lanes take the shift result. The mask can be overridden by a no-mask flag. Lanes that are not written are either cleared or left holding their old destination value, as selected by a zeroing flag. For 32-bit and 64-bit elements, one count taken from element 0 can be broadcast to every lane. The whole result is captured in one output register when the input strobe is high, and every bit above the active length is cleared.

Top module: `fsh_vec_unit`

## Requirements
- R1: For every active lane, the result is the upper element-width bits of {dst element, src element} shifted left by the lane's count.
- R2: The count used by a lane is its count element ANDed with (element width − 1), so count bits at and above that mask have no effect.
- R3: A count of zero gives back the old destination element, and no bit ever moves from one lane into another.
- R4: esize encodes 0 = 16-bit, 1 = 32-bit, 2 = 64-bit; vlen encodes 0 = 128, 1 = 256, 2 = 512 bits; code 3 is reserved in both. There are vector length / element width lanes, lane j takes kmask bit j, and mask bits at and above the lane count are ignored.
- R5: A lane whose mask bit is 0 (with nomask low) becomes zero when zeroing is 1, and keeps its old destination element when zeroing is 0.
- R6: When nomask is 1, every active lane takes the shift result whatever kmask holds.
- R7: All result bits at and above the active vector length, up to bit 511, are zero.
- R8: With bcast high and 32-bit or 64-bit elements, every lane uses count element 0. With 16-bit elements, bcast has no effect.
- R9: res and out_valid update at the clock edge after in_valid is sampled high. When in_valid is low, out_valid drops and res holds its value. A synchronous active-high rst clears both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation strobe |
| esize | input | 2 | Element size select |
| vlen | input | 2 | Active vector length select |
| dst_in | input | 512 | Old destination / accumulator vector |
| src_in | input | 512 | Second source vector |
| cnt_in | input | 512 | Per-lane shift counts |
| bcast | input | 1 | Use count element 0 for all lanes |
| kmask | input | 32 | Per-lane write mask |
| nomask | input | 1 | Write all active lanes |
| zeroing | input | 1 | Clear (1) or keep (0) unwritten lanes |
| out_valid | output | 1 | Result valid |
| res | output | 512 | Updated destination vector |

## Verification
The assertions assume that whenever in_valid is high, neither esize nor vlen carries the reserved code 3; one assertion guards this assumption directly. The stimulus loops only over the nine legal size and length pairs, so that assumption always holds. Within those pairs it covers all three mask modes and both broadcast settings. It also uses count vectors with bits set above the count mask, and mask words with bits set beyond the lane count, so that the masking and ignore rules are exercised without ever leaving the legal encodings.

// File: rtl/fsh_pkg.sv
package fsh_pkg;

  typedef enum logic [1:0] {
    ES16   = 2'd0,
    ES32   = 2'd1,
    ES64   = 2'd2,
    ES_RSV = 2'd3
  } esz_t;

  typedef enum logic [1:0] {
    VL128  = 2'd0,
    VL256  = 2'd1,
    VL512  = 2'd2,
    VL_RSV = 2'd3
  } vlen_t;

  localparam int BASE_EW  = 16;
  localparam int N_ESIZES = 3;

  // Element width for a given size code.
  function automatic int elem_width(input esz_t e);
    return BASE_EW << int'(e);
  endfunction

endpackage

// File: rtl/fsh_lane_bank.sv
// One bank of funnel lanes at a fixed element width; combinational.
module fsh_lane_bank #(
  parameter int VEC_W    = 512,
  parameter int EW       = 16,
  parameter int MASK_W   = 32,
  parameter bit BCAST_OK = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [VEC_W-1:0]  dst,
  input  logic [VEC_W-1:0]  src,
  input  logic [VEC_W-1:0]  cnt,
  input  logic              bcast,
  input  logic [MASK_W-1:0] kmask,
  input  logic              nomask,
  input  logic              zeroing,
  output logic [VEC_W-1:0]  lanes_out
);

  localparam int NLANE = VEC_W / EW;
  localparam int SHW   = $clog2(EW);

  // Upper half of {hi,lo} shifted left by sh.
  function automatic logic [EW-1:0] funnel_hi(input logic [EW-1:0]  hi,
                                              input logic [EW-1:0]  lo,
                                              input logic [SHW-1:0] sh);
    logic [2*EW-1:0] cat;
    cat = {hi, lo} << sh;
    return cat[2*EW-1:EW];
  endfunction

  logic unused_bcast;
  generate
    if (BCAST_OK) begin : g_bc_used
      assign unused_bcast = 1'b0;
    end else begin : g_bc_unused
      assign unused_bcast = bcast;
    end
  endgenerate

  genvar j;
  generate
    for (j = 0; j < NLANE; j++) begin : g_lane
      logic [EW-1:0]  d_e, s_e, c_e, f_e;
      logic [SHW-1:0] sh_e;
      logic           wr_e;
      logic           unused_cnt_hi;

      assign d_e = dst[j*EW +: EW];
      assign s_e = src[j*EW +: EW];

      if (BCAST_OK) begin : g_cnt_bc
        assign c_e = bcast ? cnt[EW-1:0] : cnt[j*EW +: EW];
      end else begin : g_cnt_lane
        assign c_e = cnt[j*EW +: EW];
      end

      // Masking with EW-1 keeps only the low SHW bits.
      assign sh_e          = c_e[SHW-1:0];
      assign unused_cnt_hi = ^c_e[EW-1:SHW];
      assign f_e           = funnel_hi(d_e, s_e, sh_e);
      assign wr_e          = nomask | kmask[j];

      assign lanes_out[j*EW +: EW] = wr_e ? f_e : (zeroing ? '0 : d_e);

      AST_ZERO_SHIFT_KEEPS_DST: assert property (@(posedge clk) disable iff (rst)
        (sh_e == '0) |-> (f_e == d_e)); // R3
      AST_UNWRITTEN_LANE: assert property (@(posedge clk) disable iff (rst)
        (!wr_e) |-> (lanes_out[j*EW +: EW] == (zeroing ? '0 : d_e))); // R5
    end
  endgenerate

endmodule

// File: rtl/fsh_tail_clear.sv
// Clears every GRAN-bit chunk at or above the active vector length.
module fsh_tail_clear #(
  parameter int VEC_W = 512,
  parameter int GRAN  = 128
) (
  input  logic [1:0]       vlen,
  input  logic [VEC_W-1:0] din,
  output logic [VEC_W-1:0] dout
);

  localparam int NCH = VEC_W / GRAN;
  localparam int CW  = $clog2(NCH) + 2;

  logic [CW-1:0] active_chunks;
  assign active_chunks = CW'(1) << vlen;

  genvar i;
  generate
    for (i = 0; i < NCH; i++) begin : g_chunk
      logic keep;
      assign keep = (CW'(i) < active_chunks);
      assign dout[i*GRAN +: GRAN] = keep ? din[i*GRAN +: GRAN] : '0;
    end
  endgenerate

endmodule

// File: rtl/fsh_vec_unit.sv
module fsh_vec_unit #(
  parameter int VEC_W  = 512,
  parameter int MASK_W = 32,
  parameter int GRAN   = 128
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [1:0]        esize,
  input  logic [1:0]        vlen,
  input  logic [VEC_W-1:0]  dst_in,
  input  logic [VEC_W-1:0]  src_in,
  input  logic [VEC_W-1:0]  cnt_in,
  input  logic              bcast,
  input  logic [MASK_W-1:0] kmask,
  input  logic              nomask,
  input  logic              zeroing,
  output logic              out_valid,
  output logic [VEC_W-1:0]  res
);
  import fsh_pkg::*;

  logic [VEC_W-1:0] bank_res [N_ESIZES];
  logic [VEC_W-1:0] sel_res;
  logic [VEC_W-1:0] tail_res;
  esz_t             esz_sel;
  vlen_t            q_vlen;

  assign esz_sel = esz_t'(esize);

  genvar g;
  generate
    for (g = 0; g < N_ESIZES; g++) begin : g_bank
      fsh_lane_bank #(
        .VEC_W   (VEC_W),
        .EW      (BASE_EW << g),
        .MASK_W  (MASK_W),
        .BCAST_OK(g != 0)
      ) u_bank (
        .clk      (clk),
        .rst      (rst),
        .dst      (dst_in),
        .src      (src_in),
        .cnt      (cnt_in),
        .bcast    (bcast),
        .kmask    (kmask),
        .nomask   (nomask),
        .zeroing  (zeroing),
        .lanes_out(bank_res[g])
      );
    end
  endgenerate

  always_comb begin
    case (esz_sel)
      ES16:    sel_res = bank_res[0];
      ES32:    sel_res = bank_res[1];
      ES64:    sel_res = bank_res[2];
      default: sel_res = '0;
    endcase
  end

  fsh_tail_clear #(
    .VEC_W(VEC_W),
    .GRAN (GRAN)
  ) u_tail (
    .vlen(vlen),
    .din (sel_res),
    .dout(tail_res)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      res       <= '0;
      q_vlen    <= VL512;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        res    <= tail_res;
        q_vlen <= vlen_t'(vlen);
      end
    end
  end

  AST_CFG_LEGAL: assert property (@(posedge clk) disable iff (rst)
    in_valid |-> (esize != 2'd3 && vlen != 2'd3)); // R4
  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid); // R9
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && $stable(res))); // R9
  AST_TAIL_ZERO_128: assert property (@(posedge clk) disable iff (rst)
    (out_valid && q_vlen == VL128) |-> (res[VEC_W-1:GRAN] == '0)); // R7
  AST_TAIL_ZERO_256: assert property (@(posedge clk) disable iff (rst)
    (out_valid && q_vlen == VL256) |-> (res[VEC_W-1:2*GRAN] == '0)); // R7
  AST_ALL_ZEROED: assert property (@(posedge clk) disable iff (rst)
    (in_valid && zeroing && !nomask && kmask == '0) |=> (res == '0)); // R5

endmodule

// File: tb/fsh_vec_unit_bench.sv
module fsh_vec_unit_bench;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic [1:0]   esize = 2'd0;
  logic [1:0]   vlen = 2'd0;
  logic [511:0] dst_in = '0, src_in = '0, cnt_in = '0;
  logic         bcast = 1'b0;
  logic [31:0]  kmask = '0;
  logic         nomask = 1'b0, zeroing = 1'b0;
  logic         out_valid;
  logic [511:0] res;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  logic         mv = 1'b0;
  logic [511:0] mr = '0;

  always #10 clk = ~clk;

  fsh_vec_unit u_fsh_vec_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .esize(esize), .vlen(vlen),
    .dst_in(dst_in), .src_in(src_in), .cnt_in(cnt_in), .bcast(bcast),
    .kmask(kmask), .nomask(nomask), .zeroing(zeroing),
    .out_valid(out_valid), .res(res)
  );

  // Behavioural reference, written from the requirements.
  function automatic logic [511:0] ref_calc(
      input logic [511:0] d, input logic [511:0] s, input logic [511:0] c,
      input logic [31:0] k, input int esz, input int vl,
      input bit bc, input bit nm, input bit zr);
    logic [511:0] out, t;
    logic [127:0] m, dj, sj, cj, wide, r;
    int ew, lanes, sh;
    out   = '0;
    ew    = 16 << esz;
    lanes = (128 << vl) / ew;
    m     = (128'd1 << ew) - 128'd1;
    for (int j = 0; j < lanes; j++) begin
      t  = d >> (j * ew);  dj = t[127:0] & m;
      t  = s >> (j * ew);  sj = t[127:0] & m;
      if (bc && esz != 0) t = c;
      else                t = c >> (j * ew);
      cj = t[127:0] & m;
      sh = int'(cj[6:0]) % ew;
      wide = ((dj << ew) | sj) << sh;
      r    = (wide >> ew) & m;
      if (!(nm || k[j])) r = zr ? 128'd0 : dj;
      t = '0;
      t[127:0] = r;
      out = out | (t << (j * ew));
    end
    return out;
  endfunction

  function automatic logic [511:0] rnd512();
    logic [511:0] v;
    for (int i = 0; i < 16; i++) v[i*32 +: 32] = $urandom;
    return v;
  endfunction

  task automatic check(input string tag);
    checks++;
    if (out_valid !== mv) begin
      errors++;
      $display("FAIL %s out_valid actual=%0b expected=%0b", tag, out_valid, mv);
    end
    checks++;
    if (res !== mr) begin
      errors++;
      $display("FAIL %s res actual=%h expected=%h", tag, res, mr);
    end
  endtask

  // Update model for the coming edge, let the edge pass, compare.
  task automatic step(input string tag);
    if (rst) begin
      mv = 1'b0; mr = '0;
    end else if (in_valid) begin
      mv = 1'b1;
      mr = ref_calc(dst_in, src_in, cnt_in, kmask, int'(esize), int'(vlen),
                    bcast, nomask, zeroing);
    end else begin
      mv = 1'b0;
    end
    @(posedge clk);
    @(negedge clk);
    check(tag);
  endtask

  task automatic op(input int esz, input int vl, input logic [511:0] d,
                    input logic [511:0] s, input logic [511:0] c,
                    input logic [31:0] k, input bit bc, input bit nm,
                    input bit zr, input string tag);
    in_valid = 1'b1; esize = 2'(esz); vlen = 2'(vl);
    dst_in = d; src_in = s; cnt_in = c; kmask = k;
    bcast = bc; nomask = nm; zeroing = zr;
    step(tag);
    in_valid = 1'b0;
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    step("R9 reset");
    step("R9 reset");
    rst = 1'b0;
    step("R9 idle after reset");

    // Sweep: all legal size/length pairs, mask modes, broadcast.
    for (int e = 0; e < 3; e++)
      for (int v = 0; v < 3; v++)
        for (int md = 0; md < 3; md++)
          for (int b = 0; b < 2; b++)
            for (int n = 0; n < 3; n++)
              op(e, v, rnd512(), rnd512(), rnd512(), $urandom, b[0],
                 md == 0, md == 2, "R1 R4 R5 R6 R7 R8 sweep");

    // R2: all count bits set -> effective count width-1; also exact width-1.
    for (int e = 0; e < 3; e++) begin
      logic [511:0] cexact;
      cexact = '0;
      for (int j = 0; j < 512 / (16 << e); j++)
        cexact[j*(16 << e) +: 7] = 7'((16 << e) - 1);
      op(e, 2, rnd512(), rnd512(), {512{1'b1}}, '1, 0, 1, 0, "R2 count high bits set");
      op(e, 2, rnd512(), rnd512(), cexact, '1, 0, 1, 0, "R2 count width-1");
    end

    // R3: zero counts return dst; all-ones src with zero count leaks nothing.
    for (int e = 0; e < 3; e++) begin
      op(e, 2, rnd512(), rnd512(), '0, '1, 0, 1, 0, "R3 zero count");
      op(e, 2, '0, {512{1'b1}}, '0, '1, 0, 1, 0, "R3 no cross-lane carry");
    end

    // R4: mask bits beyond the lane count are ignored (64-bit, 128 length).
    op(2, 0, rnd512(), rnd512(), rnd512(), 32'hFFFF_FFFC, 0, 0, 1, "R4 high mask bits");
    // R5: empty mask with zeroing clears, with merging keeps dst.
    op(1, 2, rnd512(), rnd512(), rnd512(), '0, 0, 0, 1, "R5 zero all");
    op(1, 2, rnd512(), rnd512(), rnd512(), '0, 0, 0, 0, "R5 merge all");
    // R6: nomask overrides an empty mask.
    op(0, 1, rnd512(), rnd512(), rnd512(), '0, 0, 1, 1, "R6 nomask");
    // R8: bcast ignored at 16-bit, honoured at 64-bit.
    op(0, 2, rnd512(), rnd512(), rnd512(), '1, 1, 1, 0, "R8 bcast ignored 16");
    op(2, 2, rnd512(), rnd512(), rnd512(), '1, 1, 1, 0, "R8 bcast 64");
    // R7: short length with full-width operands.
    op(1, 0, {512{1'b1}}, {512{1'b1}}, rnd512(), '1, 0, 1, 0, "R7 tail clear");

    // R9: idle cycles hold res; reset mid-run clears it.
    step("R9 hold");
    step("R9 hold");
    in_valid = 1'b1; rst = 1'b1;
    step("R9 reset overrides valid");
    rst = 1'b0; in_valid = 1'b0;
    step("R9 after reset");

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule